// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Update Handshake

The block turns a free-running parent clock into a clock-enable pulse train whose average rate is the parent rate times mult/32. In every frame of 32 parent cycles the enable is high on exactly mult cycles. The pulses are spread evenly across the frame by a phase accumulator, so they do not arrive as one burst. Logic downstream runs on the parent clock and advances only on cycles where the enable is high.

Software programs the ratio through a small word-addressed register port. A 5-bit field holds the ratio in inverted form, so mult = 32 - field and the range is 1 to 32. A written field stays pending until software sets an update-request bit in a second register. The hardware copies the pending field into the generator at the next frame boundary. One cycle later it clears the request bit, and software polls that bit to learn that the change is complete. While the request bit reads 1, the block ignores every write to either register.

Top module: `frac_clken_top`

## Requirements
- R1: After reset the ratio register and the request register both read 0. The effective multiplier is therefore 32, and the enable is high on every cycle.
- R2: The ratio field is bits 12:8 of the ratio register at word address 0. The active multiplier is 32 minus the active field, and each 32-cycle frame contains exactly that many enable cycles.
- R3: In frame cycle k (k = 0 to 31, with cycle 0 being the first cycle after reset or after a frame boundary), the enable equals floor((k+1)·mult/32) − floor(k·mult/32).
- R4: Writing the ratio field without a request leaves the enable pattern unchanged. The new field still reads back at once.
- R5: A write to word address 1 that has byte lane 3 enabled and bit 31 set to 1 sets the request bit. The bit reads back as 1 in the following cycle.
- R6: A pending ratio takes effect at the first frame boundary that follows the setting of the request bit. The request bit then reads 0 from frame cycle 1 of the new frame onward.
- R7: While the request bit reads 1, writes to both registers are ignored. The readback values do not change, and the ratio applied is the one that was pending before the request.
- R8: Writes honour a 4-bit byte-lane enable, where lane i covers bits 8i+7:8i. Bits outside the defined fields keep and read back the last value written to them.
- R9: Word addresses 2 and 3 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address for reads and writes |
| regWrData | input | 32 | Write data |
| regByteEn | input | 4 | Byte-lane write enables |
| regRdData | output | 32 | Combinational read data for regAddr |
| clkEnOut | output | 1 | Clock-enable pulse train |

## Verification
Two kinds of internal fault show at the ports. A wrong accumulator phase or a wrong active multiplier changes the enable within the same frame: a cycle pattern that differs from the floor formula, or a per-frame pulse count other than mult. A fault in the handshake shows as the request bit clearing at a frame position other than cycle 1, or as a busy write altering the readback. The bench therefore sweeps all 32 field values and compares every cycle of a full frame. It also times the clearing of the request bit to the exact cycle.

// File: rtl/frac_clken_pkg.sv
package frac_clken_pkg;
  localparam int DataW    = 32;
  localparam int LaneCnt  = DataW / 8;
  localparam int AddrW    = 2;
  localparam int FieldW   = 5;
  localparam int FieldLsb = 8;
  localparam int KickBit  = 31;
  localparam int FrameLen = 1 << FieldW;
  localparam int MultW    = FieldW + 1;

  typedef struct packed {
    logic              loadRatio;
    logic [FieldW-1:0] newField;
  } ratio_stb_t;
endpackage

// File: rtl/frac_clken_bytemerge.sv
module frac_clken_bytemerge #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] oldWord,
  input  logic [LANES*8-1:0] newWord,
  input  logic [LANES-1:0]   laneEn,
  output logic [LANES*8-1:0] mergedWord
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[g*8 +: 8] = laneEn[g] ? newWord[g*8 +: 8] : oldWord[g*8 +: 8];
  end
endmodule

// File: rtl/frac_clken_ctrl.sv
module frac_clken_ctrl
  import frac_clken_pkg::*;
#(
  parameter logic [AddrW-1:0] RATIO_ADDR = 2'd0,
  parameter logic [AddrW-1:0] KICK_ADDR  = 2'd1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [AddrW-1:0]   regAddr,
  input  logic [DataW-1:0]   regWrData,
  input  logic [LaneCnt-1:0] regByteEn,
  input  logic               frameEnd,
  output logic [DataW-1:0]   regRdData,
  output logic               kickBusy,
  output ratio_stb_t         ratioStb
);
  logic [DataW-1:0] ratioReg;
  logic [DataW-1:0] kickReg;
  logic [DataW-1:0] ratioMerged;
  logic [DataW-1:0] kickMerged;
  logic             applyDone;
  logic             wrRatio;
  logic             wrKick;

  frac_clken_bytemerge #(.LANES(LaneCnt)) i_mergeRatio (
    .oldWord(ratioReg), .newWord(regWrData), .laneEn(regByteEn), .mergedWord(ratioMerged)
  );
  frac_clken_bytemerge #(.LANES(LaneCnt)) i_mergeKick (
    .oldWord(kickReg), .newWord(regWrData), .laneEn(regByteEn), .mergedWord(kickMerged)
  );

  assign kickBusy = kickReg[KickBit];
  assign wrRatio  = regWrEn && (regAddr == RATIO_ADDR) && !kickBusy;
  assign wrKick   = regWrEn && (regAddr == KICK_ADDR) && !kickBusy;

  always_comb begin
    ratioStb.loadRatio = kickBusy && frameEnd && !applyDone;
    ratioStb.newField  = ratioReg[FieldLsb +: FieldW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioReg  <= '0;
      kickReg   <= '0;
      applyDone <= 1'b0;
    end else begin
      if (wrRatio) ratioReg <= ratioMerged;
      if (applyDone) begin
        kickReg[KickBit] <= 1'b0;
        applyDone        <= 1'b0;
      end else begin
        if (wrKick) kickReg <= kickMerged;
        if (ratioStb.loadRatio) applyDone <= 1'b1;
      end
    end
  end

  always_comb begin
    if (regAddr == RATIO_ADDR)     regRdData = ratioReg;
    else if (regAddr == KICK_ADDR) regRdData = kickReg;
    else                           regRdData = '0;
  end
endmodule

// File: rtl/frac_clken_dp.sv
module frac_clken_dp
  import frac_clken_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ratio_stb_t       ratioStb,
  output logic             frameEnd,
  output logic [MultW-1:0] multNow,
  output logic             clkEnOut
);
  logic [FieldW-1:0] activeField;
  logic [FieldW-1:0] frameCnt;
  logic [FieldW-1:0] phaseAcc;
  logic [MultW-1:0]  phaseSum;

  assign multNow  = MultW'(FrameLen) - {1'b0, activeField};
  assign frameEnd = &frameCnt;
  assign phaseSum = {1'b0, phaseAcc} + multNow;
  assign clkEnOut = phaseSum[FieldW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeField <= '0;
      frameCnt    <= '0;
      phaseAcc    <= '0;
    end else begin
      frameCnt <= frameCnt + 1'b1;
      phaseAcc <= phaseSum[FieldW-1:0];
      if (ratioStb.loadRatio) activeField <= ratioStb.newField;
    end
  end
endmodule

// File: rtl/frac_clken_top.sv
module frac_clken_top
  import frac_clken_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [AddrW-1:0]   regAddr,
  input  logic [DataW-1:0]   regWrData,
  input  logic [LaneCnt-1:0] regByteEn,
  output logic [DataW-1:0]   regRdData,
  output logic               clkEnOut
);
  ratio_stb_t       ratioStb;
  logic             kickBusy;
  logic             frameEnd;
  logic [MultW-1:0] multNow;

  frac_clken_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regByteEn(regByteEn), .frameEnd(frameEnd),
    .regRdData(regRdData), .kickBusy(kickBusy), .ratioStb(ratioStb)
  );

  frac_clken_dp i_dp (
    .clk(clk), .rstN(rstN), .ratioStb(ratioStb), .frameEnd(frameEnd),
    .multNow(multNow), .clkEnOut(clkEnOut)
  );
endmodule

// File: rtl/frac_clken_chk.sv
module frac_clken_chk
  import frac_clken_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clkEnOut,
  input logic              kickBusy,
  input logic              loadRatio,
  input logic [FieldW-1:0] pendField,
  input logic              frameEnd,
  input logic [MultW-1:0]  multNow
);
  logic [MultW-1:0] enCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enCnt <= '0;
    else if (frameEnd) enCnt <= '0;
    else               enCnt <= enCnt + MultW'(clkEnOut);
  end

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (multNow == MultW'(FrameLen)) |-> clkEnOut); // R1
  AST_FRAME_PULSES: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ((enCnt + MultW'(clkEnOut)) == multNow)); // R2
  AST_LOAD_ON_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    loadRatio |-> frameEnd); // R6
  AST_LOAD_CLEARS_KICK: assert property (@(posedge clk) disable iff (!rstN)
    loadRatio |=> (kickBusy ##1 !kickBusy)); // R6
  AST_KICK_FALL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kickBusy) |-> $past(loadRatio, 2)); // R6
  AST_MULT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(multNow) |-> $past(frameEnd)); // R6
  AST_BUSY_HOLDS_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    kickBusy |=> $stable(pendField)); // R7
endmodule

bind frac_clken_top frac_clken_chk i_chk (
  .clk(clk), .rstN(rstN), .clkEnOut(clkEnOut), .kickBusy(kickBusy),
  .loadRatio(ratioStb.loadRatio), .pendField(ratioStb.newField),
  .frameEnd(frameEnd), .multNow(multNow)
);

// File: tb/test_frac_clken_top.sv
module test_frac_clken_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regRdData;
  logic        clkEnOut;

  int checkCnt = 0;
  int failCnt = 0;
  bit doneFlag = 0;
  logic [4:0] posCnt;

  frac_clken_top i_frac_clken_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regByteEn(regByteEn), .regRdData(regRdData),
    .clkEnOut(clkEnOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) posCnt <= '0;
    else       posCnt <= posCnt + 5'd1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regAddr = a; regWrData = d; regByteEn = be; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic int expEn(input int k, input int m);
    return ((k + 1) * m) / 32 - (k * m) / 32;
  endfunction

  task automatic checkFrame(input int m, input string tag);
    int bad = 0;
    int firstK = -1;
    int pulses = 0;
    while (posCnt != 5'd0) @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      if (clkEnOut) pulses++;
      if (int'(clkEnOut) != expEn(k, m)) begin
        bad++;
        if (firstK < 0) firstK = k;
      end
      @(negedge clk);
    end
    check(bad == 0, {tag, " enable pattern (first bad cycle index as actual)"}, firstK, -1);
    check(pulses == m, {tag, " pulses per frame"}, pulses, m);
  endtask

  task automatic startKick(input logic [31:0] d);
    logic [31:0] r;
    wrReg(2'd1, d, 4'b1000);
    rdReg(2'd1, r);
    check(r[31] == 1'b1, "R5 request bit set", int'(r[31]), 1);
  endtask

  task automatic waitKickClear();
    logic [31:0] r;
    int guard = 0;
    rdReg(2'd1, r);
    while (r[31] && guard < 100) begin
      @(negedge clk);
      rdReg(2'd1, r);
      guard++;
    end
    check(r[31] == 1'b0 && posCnt == 5'd1, "R6 request clears at frame cycle 1",
          int'(posCnt), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      failCnt++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int prevM;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(2'd0, r);
    check(r == 32'h0, "R1 ratio register reset", r, 0);
    rdReg(2'd1, r);
    check(r == 32'h0, "R1 request register reset", r, 0);
    checkFrame(32, "R1");

    // R2 R3 R4 R5 R6 sweep of every field value
    prevM = 32;
    for (int f = 0; f < 32; f++) begin
      wrReg(2'd0, 32'(f) << 8, 4'b0010);
      rdReg(2'd0, r);
      check(((r >> 8) & 32'h1f) == 32'(f), "R4 pending field readback", r, f << 8);
      checkFrame(prevM, "R4");
      startKick(32'h8000_0000);
      waitKickClear();
      checkFrame(32 - f, "R3");
      prevM = 32 - f;
    end

    // R7 writes ignored while the request is pending
    wrReg(2'd0, 32'h0000_0400, 4'b0010);
    while (posCnt != 5'd5) @(negedge clk);
    startKick(32'h8000_0000);
    wrReg(2'd0, 32'h0000_0900, 4'b1111);
    wrReg(2'd1, 32'h0000_1234, 4'b1111);
    rdReg(2'd0, r);
    check(r == 32'h0000_0400, "R7 ratio write ignored while busy", r, 32'h400);
    rdReg(2'd1, r);
    check(r == 32'h8000_0000, "R7 request write ignored while busy", r, 32'h8000_0000);
    waitKickClear();
    checkFrame(28, "R7");

    // R8 byte lanes and retained bits
    wrReg(2'd0, 32'hA5A5_A5A5, 4'b1111);
    wrReg(2'd0, 32'h0000_005A, 4'b0001);
    rdReg(2'd0, r);
    check(r == 32'hA5A5_A55A, "R8 byte lane merge ratio", r, 32'hA5A5_A55A);
    wrReg(2'd1, 32'h8000_0000, 4'b0111);
    rdReg(2'd1, r);
    check(r == 32'h0, "R8 request bit needs lane 3", r, 0);
    wrReg(2'd1, 32'h0000_00C3, 4'b0001);
    startKick(32'h8000_0000);
    rdReg(2'd1, r);
    check(r == 32'h8000_00C3, "R8 request register other bits kept", r, 32'h8000_00C3);
    waitKickClear();
    rdReg(2'd1, r);
    check(r == 32'h0000_00C3, "R8 other bits kept after clear", r, 32'hC3);
    checkFrame(27, "R2");

    // R9 unused addresses
    rdReg(2'd2, r);
    check(r == 32'h0, "R9 address 2 reads zero", r, 0);
    wrReg(2'd3, 32'hFFFF_FFFF, 4'b1111);
    rdReg(2'd3, r);
    check(r == 32'h0, "R9 address 3 reads zero", r, 0);
    rdReg(2'd0, r);
    check(r == 32'hA5A5_A55A, "R9 ratio untouched", r, 32'hA5A5_A55A);
    rdReg(2'd1, r);
    check(r == 32'h0000_00C3, "R9 request untouched", r, 32'hC3);
    checkFrame(27, "R9");

    doneFlag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule